// File: doc/BRIEF.md
# SDRAM Command Encoder for Registered Modules

This block sits between a memory controller's scheduler and the command pins of a registered SDRAM module. The scheduler presents one abstract request per clock over a valid/ready handshake. The encoder turns the request into chip-select, row strobe, column strobe, write enable, clock enable, bank and address values, and holds them on registered outputs for exactly one cycle. Cycles with no accepted request carry a no-operation command.

The encoder also tracks the CAS latency the scheduler last programmed. It uses that latency to raise a read-data-valid strobe at the right cycle. The strobe allows one extra cycle for the register on the module. The encoder also places the data mask with the lead each direction needs. A write mask shares the cycle of the write command. A read mask must reach the device two cycles before the data it blanks.

Self refresh is entered through a request. While the device is in self refresh, the encoder holds clock enable low and refuses new requests. When a request is waiting, the encoder spends one no-operation cycle with clock enable high to exit self refresh, and then resumes normal operation.

Top module: `sdram_cmd_enc`

## Requirements
- R1: While rst_ni is low, the outputs show {cs_n,ras_n,cas_n,we_n}=1111, cke=1, a=0, ba=0, dqm=0, rd_valid=0 and req_ready=0. From the first clock edge after reset is released, ready is high and the outputs show a no-operation command.
- R2: A request accepted at a clock edge (valid and ready both high) appears on the pins in the following cycle, for that cycle only. A cycle with no accepted request, outside self refresh, shows {cs_n,ras_n,cas_n,we_n}=0111 with a=0, ba=0 and cke=1.
- R3: The request codes on req_op_i are 0 nop, 1 activate, 2 read, 3 write, 4 burst stop, 5 precharge one bank, 6 precharge all, 7 auto refresh, 8 self refresh, 9 load mode. They map to the pin codes {cs_n,ras_n,cas_n,we_n} as follows: activate 0011, read 0101, write 0100, burst stop 0110, both precharges 0010, both refreshes 0001, load mode 0000. Codes 10 to 15 give a nop.
- R4: Activate drives a = req_row_i and ba = req_bank_i.
- R5: Read and write drive a[9:0] = req_col_i[9:0], a[11] = req_col_i[10], a[10] = req_ap_i (auto-precharge), a[12] = 0 and ba = req_bank_i.
- R6: Precharge of one bank drives a = 0 (a[10] low) and ba = req_bank_i. Precharge of all banks drives a = 13'h0400 (a[10] high) and ba = 0, whatever the bank input holds.
- R7: Auto refresh drives cke = 1, a = 0 and ba = 0. Self refresh entry drives the same pin code with cke = 0.
- R8: After self refresh entry, cke stays low, ready stays low and the pins show nop for as long as req_valid_i is low. The first edge that sees req_valid_i high produces one nop cycle with cke = 1, and ready is high in that same cycle.
- R9: Load mode drives a[11:0] = req_mode_i, a[12] = 0 and ba = 0. If req_mode_i[6:4] is 2 or 3, that value becomes the CAS latency for later reads. Any other value leaves the latency unchanged. The latency after reset is 3.
- R10: rd_valid_o is high for one cycle, exactly CL+1 cycles after the cycle in which a read is on the pins.
- R11: A write with req_mask_i set drives dqm_o high in the cycle the write command is on the pins. A write without the mask leaves dqm_o low.
- R12: A read with req_mask_i set drives dqm_o high for one cycle, CL-2 cycles after the read command cycle (the same cycle when CL=2, the next cycle when CL=3). An unmasked read never raises dqm_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Encoder can accept a request this cycle |
| req_op_i | input | 4 | Request code |
| req_bank_i | input | 2 | Bank select |
| req_row_i | input | 13 | Row address for activate |
| req_col_i | input | 11 | Column address for read/write |
| req_ap_i | input | 1 | Auto-precharge after the burst |
| req_mode_i | input | 12 | Mode register op-code |
| req_mask_i | input | 1 | Mask the write data or the first read beat |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| ba_o | output | 2 | Bank address |
| a_o | output | 13 | Address bus |
| dqm_o | output | 1 | Data mask |
| rd_valid_o | output | 1 | Read data returns this cycle |

## Verification
A stale latency register has a visible signature. The read strobe lands one cycle early or late, and a masked read raises dqm in the wrong cycle. Both show within four cycles of the first read after the load mode that should have changed the latency. A self refresh flag that stays set or clears early shows up right away in the same cycle, as cke and ready disagree with the number of nop cycles seen since entry. An address mux fault corrupts a, ba or the pin code in the one cycle after the request is accepted.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ACT  = 4'd1,
    OP_RD   = 4'd2,
    OP_WR   = 4'd3,
    OP_BST  = 4'd4,
    OP_PRE  = 4'd5,
    OP_PREA = 4'd6,
    OP_REF  = 4'd7,
    OP_SREF = 4'd8,
    OP_LMR  = 4'd9
  } req_op_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_INH = 4'b1111;
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_ACT = 4'b0011;
  localparam logic [3:0] PIN_RD  = 4'b0101;
  localparam logic [3:0] PIN_WR  = 4'b0100;
  localparam logic [3:0] PIN_BST = 4'b0110;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_REF = 4'b0001;
  localparam logic [3:0] PIN_LMR = 4'b0000;
endpackage

// File: rtl/sdram_cmd_map.sv
module sdram_cmd_map
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11,
  parameter int BANK_W = 2,
  parameter int MODE_W = 12,
  parameter int AP_BIT = 10
) (
  input  req_op_e            op_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic               ap_i,
  input  logic [MODE_W-1:0]  mode_i,
  output logic [3:0]         pins_o,
  output logic               cke_o,
  output logic [BANK_W-1:0]  ba_o,
  output logic [ROW_W-1:0]   a_o
);
  logic [ROW_W-1:0] col_addr;

  // column bits skip the auto-precharge position
  always_comb begin
    col_addr = '0;
    col_addr[AP_BIT-1:0]     = col_i[AP_BIT-1:0];
    col_addr[AP_BIT]         = ap_i;
    col_addr[COL_W:AP_BIT+1] = col_i[COL_W-1:AP_BIT];
  end

  always_comb begin
    pins_o = PIN_NOP;
    cke_o  = 1'b1;
    ba_o   = '0;
    a_o    = '0;
    case (op_i)
      OP_ACT: begin
        pins_o = PIN_ACT;
        ba_o   = bank_i;
        a_o    = row_i;
      end
      OP_RD: begin
        pins_o = PIN_RD;
        ba_o   = bank_i;
        a_o    = col_addr;
      end
      OP_WR: begin
        pins_o = PIN_WR;
        ba_o   = bank_i;
        a_o    = col_addr;
      end
      OP_BST:  pins_o = PIN_BST;
      OP_PRE: begin
        pins_o = PIN_PRE;
        ba_o   = bank_i;
      end
      OP_PREA: begin
        pins_o    = PIN_PRE;
        a_o[AP_BIT] = 1'b1;
      end
      OP_REF:  pins_o = PIN_REF;
      OP_SREF: begin
        pins_o = PIN_REF;
        cke_o  = 1'b0;
      end
      OP_LMR: begin
        pins_o = PIN_LMR;
        a_o[MODE_W-1:0] = mode_i;
      end
      default: pins_o = PIN_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe #(
  parameter int DEPTH = 5,
  parameter int POS_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             out_o
);
  logic [DEPTH-1:0] q, nxt;

  // slot i reaches the output i edges after the load edge
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic up;
    if (i == DEPTH - 1) begin : g_top
      assign up = 1'b0;
    end else begin : g_mid
      assign up = q[i+1];
    end
    assign nxt[i] = up | (load_i && (pos_i == POS_W'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign out_o = q[0];
endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int COL_W    = 11,
  parameter int BANK_W   = 2,
  parameter int MODE_W   = 12,
  parameter int CL_MIN   = 2,
  parameter int CL_MAX   = 3,
  parameter int CLF_LO   = 4,
  parameter int CLF_W    = 3,
  parameter int REG_DLY  = 1,
  parameter int DQM_LEAD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        req_op_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_ap_i,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic              req_mask_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic              dqm_o,
  output logic              rd_valid_o
);
  localparam int CL_W   = $clog2(CL_MAX + 1);
  localparam int PIPE_D = CL_MAX + REG_DLY + 1;
  localparam int POS_W  = $clog2(PIPE_D);

  logic              init_q, sref_q, dqm_wr_q;
  logic [CL_W-1:0]   cl_q;
  logic [3:0]        pins_q;
  logic              cke_q;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  a_q;

  req_op_e           op;
  logic              accept;
  logic [3:0]        m_pins;
  logic              m_cke;
  logic [BANK_W-1:0] m_ba;
  logic [ROW_W-1:0]  m_a;
  logic [CLF_W-1:0]  cl_field;
  logic              cl_ok;
  logic              rd_load, rd_mask_load, dqm_rd;
  logic [POS_W-1:0]  rd_pos, dqm_pos;

  assign op          = req_op_e'(req_op_i);
  assign req_ready_o = init_q & ~sref_q;
  assign accept      = req_valid_i & req_ready_o;

  sdram_cmd_map #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .BANK_W(BANK_W),
    .MODE_W(MODE_W)
  ) u_map (
    .op_i  (op),
    .bank_i(req_bank_i),
    .row_i (req_row_i),
    .col_i (req_col_i),
    .ap_i  (req_ap_i),
    .mode_i(req_mode_i),
    .pins_o(m_pins),
    .cke_o (m_cke),
    .ba_o  (m_ba),
    .a_o   (m_a)
  );

  assign cl_field = req_mode_i[CLF_LO +: CLF_W];
  assign cl_ok    = (int'(cl_field) >= CL_MIN) && (int'(cl_field) <= CL_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= 1'b0;
      sref_q   <= 1'b0;
      cl_q     <= CL_W'(CL_MAX);
      pins_q   <= PIN_INH;
      cke_q    <= 1'b1;
      ba_q     <= '0;
      a_q      <= '0;
      dqm_wr_q <= 1'b0;
    end else begin
      init_q <= 1'b1;
      if (accept) begin
        pins_q   <= m_pins;
        cke_q    <= m_cke;
        ba_q     <= m_ba;
        a_q      <= m_a;
        sref_q   <= (op == OP_SREF);
        dqm_wr_q <= (op == OP_WR) && req_mask_i;
        if (op == OP_LMR && cl_ok) cl_q <= cl_field[CL_W-1:0];
      end else begin
        pins_q   <= PIN_NOP;
        ba_q     <= '0;
        a_q      <= '0;
        dqm_wr_q <= 1'b0;
        // a waiting request pulls the device out of self refresh
        cke_q    <= sref_q ? req_valid_i : 1'b1;
        if (sref_q && req_valid_i) sref_q <= 1'b0;
      end
    end
  end

  assign rd_load      = accept && (op == OP_RD);
  assign rd_mask_load = rd_load && req_mask_i;
  assign rd_pos       = POS_W'(int'(cl_q) + REG_DLY);
  assign dqm_pos      = POS_W'(int'(cl_q) - DQM_LEAD);

  sdram_lat_pipe #(.DEPTH(PIPE_D), .POS_W(POS_W)) u_rd_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(rd_load),
    .pos_i (rd_pos),
    .out_o (rd_valid_o)
  );

  sdram_lat_pipe #(.DEPTH(PIPE_D), .POS_W(POS_W)) u_dqm_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(rd_mask_load),
    .pos_i (dqm_pos),
    .out_o (dqm_rd)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins_q;
  assign cke_o = cke_q;
  assign ba_o  = ba_q;
  assign a_o   = a_q;
  assign dqm_o = dqm_wr_q | dqm_rd;
endmodule

// File: rtl/sdram_cmd_enc_chk.sv
module sdram_cmd_enc_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [3:0]       req_op_i,
  input logic             req_mask_i,
  input logic             cs_n_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic             cke_o,
  input logic [ROW_W-1:0] a_o,
  input logic             dqm_o,
  input logic             rd_valid_o
);
  logic [3:0] pins;
  logic       rd_on_pins, took;
  assign pins       = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign rd_on_pins = (pins == 4'b0101);
  assign took       = req_valid_i && req_ready_o;

  // R2
  idle_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !took) |=> (pins == 4'b0111));

  // R7
  sref_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (pins == 4'b0001));

  // R8
  sref_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> !req_ready_o);

  // R9
  lmr_a12_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0000) |-> !a_o[ROW_W-1]);

  // R10
  rd_valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(rd_on_pins, 3) || $past(rd_on_pins, 4)));

  // R11
  wr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (took && req_op_i == 4'd3 && req_mask_i) |=> dqm_o);
endmodule

bind sdram_cmd_enc sdram_cmd_enc_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_op_i   (req_op_i),
  .req_mask_i (req_mask_i),
  .cs_n_o     (cs_n_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .cke_o      (cke_o),
  .a_o        (a_o),
  .dqm_o      (dqm_o),
  .rd_valid_o (rd_valid_o)
);

// File: tb/sdram_cmd_enc_tb.sv
module sdram_cmd_enc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = 4'd0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic        req_ap = 1'b0;
  logic [11:0] req_mode = '0;
  logic        req_mask = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n, cke, dqm, rd_valid;
  logic [1:0]  ba;
  logic [12:0] a;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_enc u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .req_ap_i(req_ap), .req_mode_i(req_mode),
    .req_mask_i(req_mask),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .cke_o(cke), .ba_o(ba), .a_o(a), .dqm_o(dqm), .rd_valid_o(rd_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_pins(input string tag, input logic [3:0] cmd, input logic k,
                          input logic [1:0] b, input logic [12:0] ad);
    chk({tag, " cmd"}, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, cmd});
    chk({tag, " cke"}, {31'd0, cke}, {31'd0, k});
    chk({tag, " ba"}, {30'd0, ba}, {30'd0, b});
    chk({tag, " a"}, {19'd0, a}, {19'd0, ad});
  endtask

  task automatic send(input logic [3:0] op, input logic [1:0] bank, input logic [12:0] row,
                      input logic [10:0] col, input logic ap, input logic [11:0] mode,
                      input logic mask);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = bank; req_row = row;
    req_col = col; req_ap = ap; req_mode = mode; req_mask = mask;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    #23;
    chk_pins("R1 reset", 4'b1111, 1'b1, 2'd0, 13'd0);
    chk("R1 reset dqm", {31'd0, dqm}, 32'd0);
    chk("R1 reset rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk_pins("R1 idle after reset", 4'b0111, 1'b1, 2'd0, 13'd0);
  endtask

  task automatic t_act();
    send(4'd1, 2'd2, 13'h1ABC, 11'h3FF, 1'b1, 12'hFFF, 1'b0);
    chk_pins("R4 act pattern A", 4'b0011, 1'b1, 2'd2, 13'h1ABC);
    @(negedge clk);
    chk_pins("R2 one cycle then nop", 4'b0111, 1'b1, 2'd0, 13'd0);
    send(4'd1, 2'd1, 13'h0555, 11'h000, 1'b0, 12'h000, 1'b0);
    chk_pins("R4 act pattern B", 4'b0011, 1'b1, 2'd1, 13'h0555);
  endtask

  task automatic t_rw();
    send(4'd2, 2'd3, 13'h1FFF, 11'h5A5, 1'b1, 12'h000, 1'b0);
    chk_pins("R5 read ap", 4'b0101, 1'b1, 2'd3, {1'b0, 1'b1, 1'b1, 10'h1A5});
    send(4'd3, 2'd0, 13'h1FFF, 11'h20F, 1'b0, 12'h000, 1'b0);
    chk_pins("R5 write no ap", 4'b0100, 1'b1, 2'd0, {1'b0, 1'b0, 1'b0, 10'h20F});
    chk("R11 unmasked write dqm", {31'd0, dqm}, 32'd0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_pre_ref();
    send(4'd5, 2'd2, 13'h1FFF, 11'h7FF, 1'b1, 12'hFFF, 1'b0);
    chk_pins("R6 precharge one", 4'b0010, 1'b1, 2'd2, 13'h0000);
    send(4'd6, 2'd3, 13'h1FFF, 11'h7FF, 1'b0, 12'hFFF, 1'b0);
    chk_pins("R6 precharge all", 4'b0010, 1'b1, 2'd0, 13'h0400);
    send(4'd7, 2'd3, 13'h1FFF, 11'h7FF, 1'b1, 12'hFFF, 1'b0);
    chk_pins("R7 auto refresh", 4'b0001, 1'b1, 2'd0, 13'h0000);
    send(4'd4, 2'd1, 13'h0001, 11'h001, 1'b0, 12'h001, 1'b0);
    chk_pins("R3 burst stop", 4'b0110, 1'b1, 2'd0, 13'h0000);
    send(4'd12, 2'd1, 13'h0001, 11'h001, 1'b0, 12'h001, 1'b0);
    chk_pins("R3 undefined code", 4'b0111, 1'b1, 2'd0, 13'h0000);
  endtask

  task automatic t_read(input int cl, input logic m);
    send(4'd2, 2'd1, 13'h0, 11'h012, 1'b0, 12'h000, m);
    chk("R3 read code", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h5);
    for (int i = 0; i <= cl + 2; i++) begin
      if (i > 0) @(negedge clk);
      chk($sformatf("R10 rd_valid cl=%0d i=%0d", cl, i), {31'd0, rd_valid},
          {31'd0, (i == cl + 1)});
      chk($sformatf("R12 dqm cl=%0d m=%0d i=%0d", cl, m, i), {31'd0, dqm},
          {31'd0, (m && i == cl - 2)});
    end
  endtask

  task automatic t_lmr();
    send(4'd9, 2'd3, 13'h1FFF, 11'h7FF, 1'b1, 12'h020, 1'b0);
    chk_pins("R9 load mode cl2", 4'b0000, 1'b1, 2'd0, 13'h0020);
    t_read(2, 1'b1);
    t_read(2, 1'b0);
    send(4'd9, 2'd0, 13'h0, 11'h0, 1'b0, 12'hFD7, 1'b0);
    chk_pins("R9 load mode bad field", 4'b0000, 1'b1, 2'd0, 13'h0FD7);
    t_read(2, 1'b1);
    send(4'd9, 2'd0, 13'h0, 11'h0, 1'b0, 12'h030, 1'b0);
    chk_pins("R9 load mode cl3", 4'b0000, 1'b1, 2'd0, 13'h0030);
    t_read(3, 1'b1);
  endtask

  task automatic t_wmask();
    send(4'd3, 2'd1, 13'h0, 11'h044, 1'b0, 12'h000, 1'b1);
    chk("R11 masked write dqm", {31'd0, dqm}, 32'd1);
    @(negedge clk);
    chk("R11 dqm drops after write", {31'd0, dqm}, 32'd0);
  endtask

  task automatic t_sref();
    send(4'd8, 2'd0, 13'h0, 11'h0, 1'b0, 12'h000, 1'b0);
    chk_pins("R7 self refresh entry", 4'b0001, 1'b0, 2'd0, 13'd0);
    chk("R8 ready low at entry", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk_pins("R8 held", 4'b0111, 1'b0, 2'd0, 13'd0);
    chk("R8 ready held low", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_op = 4'd1; req_bank = 2'd3; req_row = 13'h0077;
    @(negedge clk);
    chk_pins("R8 exit nop", 4'b0111, 1'b1, 2'd0, 13'd0);
    chk("R8 ready back", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk_pins("R8 request after exit", 4'b0011, 1'b1, 2'd3, 13'h0077);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read(3, 1'b1);
    t_act();
    t_rw();
    t_pre_ref();
    t_wmask();
    t_lmr();
    t_sref();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule